// File: doc/BRIEF.md
# Signed Halfword Load Execution Unit

This unit executes one signed-halfword load instruction word at a time. Three addressing forms are supported: post-index and pre-index with a signed 9-bit byte offset, and an unsigned 12-bit offset scaled by two. The unit reads the base through a combinational register-file read port, and base index 31 selects the stack pointer input instead. It forms the access address and issues one 16-bit read on a valid/ready request channel. It then takes the halfword from a valid/ready response channel, sign-extends it to 32 or 64 bits and commits the result, together with any base update, in a single cycle.

Both memory channels follow the usual rule: a transfer happens on a clock edge where valid and ready are both high. While the request is waiting for `mem_req_ready`, its valid and address are held steady. `mem_rsp_ready` is high only while the unit waits for data. `in_ready` is high only when the unit is idle, so an upstream stage stalls for the whole load. A word that matches no legal encoding, or a stack-pointer base that is not 16-byte aligned, produces a one-cycle flag. In both cases the unit starts no memory access and writes no register.

Top module: `hload_unit`

## Requirements
- R1: A word is legal only when bits [31:30]=01, [29:27]=111, bit 26=0 and bit 23=1, and it also matches one of two cases. The first case is bits [25:24]=00 with bit 21=0 and bit 10=1, where bits [11:10]=01 give post-index and 11 give pre-index. The second case is bits [25:24]=01. Any other accepted word raises `illegal` in the cycle after acceptance, for one cycle, and starts no memory request and no register write.
- R2: In post-index form, the access address is the unmodified base. The base register then receives the base plus the sign-extended bits [20:12].
- R3: In pre-index form, the access address is the base plus the sign-extended bits [20:12], and that same address is written back to the base.
- R4: In the scaled form, the access address is the base plus bits [21:10] shifted left by one, giving an offset of 0 to 8190. This form never writes the base.
- R5: With bit 22=1, `res_data[31:0]` is the halfword sign-extended to 32 bits and `res_data[63:32]` is zero. With bit 22=0, `res_data` is the halfword sign-extended to 64 bits.
- R6: When bits [9:5] are 31, the base value comes from `sp_rdata`, and any writeback goes out on `sp_we`/`sp_wdata`. `base_we` then stays low.
- R7: When the stack pointer is the base and its low 4 bits are not all zero, `align_fault` is raised for one cycle after acceptance. No memory request and no register write follow.
- R8: When a form that writes back has a base index equal to the destination index (bits [4:0]), and that index is not 31, the base writeback is suppressed and the result is still written.
- R9: A destination index of 31 discards the loaded value: `res_we` stays low, while the memory access and any base writeback still happen.
- R10: `in_ready` is high only when idle. A pending request holds its address until `mem_req_ready`. All writes of one load are issued together in the cycle after the response handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction word offered |
| in_ready | output | 1 | Unit idle and accepting |
| in_word | input | 32 | Instruction word |
| rf_raddr | output | 5 | Base register read index (from in_word) |
| rf_rdata | input | 64 | General register read data |
| sp_rdata | input | 64 | Current stack pointer |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | 64 | Byte address of halfword |
| mem_rsp_valid | input | 1 | Response data valid |
| mem_rsp_ready | output | 1 | Unit waiting for data |
| mem_rsp_data | input | 16 | Returned halfword |
| res_we | output | 1 | Destination write strobe |
| res_idx | output | 5 | Destination register index |
| res_data | output | 64 | Sign-extended result |
| base_we | output | 1 | General base writeback strobe |
| base_idx | output | 5 | Base register index |
| base_data | output | 64 | Updated base address |
| sp_we | output | 1 | Stack pointer writeback strobe |
| sp_wdata | output | 64 | Updated stack pointer |
| illegal | output | 1 | Unrecognised encoding pulse |
| align_fault | output | 1 | Stack pointer misalignment pulse |

## Verification
The bench targets the most negative 9-bit offset and the largest scaled offset. A design that sign-extended the wrong field, or forgot the shift, would request the wrong address. It drives near-miss encodings: bit 21 set in an indexed form, bits [11:10] of 00 or 10, a wrong size field and a clear bit 23. Each of these would start a memory access in a design with a loose decoder. It also covers a base index equal to the destination, a zero-register destination and a stack-pointer base, both aligned and misaligned. Faults there show up as a clobbered base, a stray result write, a write to general register 31, or an access that should have been blocked. The request stalls for a varying number of cycles, so a design that dropped or changed a pending address would be caught.

// File: rtl/hload_pkg.sv
package hload_pkg;
  localparam int unsigned INSN_W    = 32;
  localparam int unsigned REG_IDX_W = 5;
  localparam logic [REG_IDX_W-1:0] SP_IDX = 5'd31;

  typedef enum logic [1:0] {
    FORM_POST = 2'd0,
    FORM_PRE  = 2'd1,
    FORM_UOFF = 2'd2
  } form_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_REQ    = 2'd1,
    ST_RSP    = 2'd2,
    ST_COMMIT = 2'd3
  } state_e;
endpackage

// File: rtl/hload_decode.sv
module hload_decode
  import hload_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic [INSN_W-1:0]    word,
  output logic                 legal,
  output form_e                form,
  output logic                 is32,
  output logic [REG_IDX_W-1:0] base_idx,
  output logic [REG_IDX_W-1:0] dst_idx,
  output logic [XLEN-1:0]      offset,
  output logic                 wback
);
  localparam int unsigned S9_W  = 9;
  localparam int unsigned U12_W = 12;

  logic fixed_ok, idx_ok, uoff_ok, overlap;

  always_comb begin
    fixed_ok = (word[31:30] == 2'b01) && (word[29:27] == 3'b111) &&
               !word[26] && word[23];
    // indexed forms: bit 21 clear, bits [11:10] either 01 or 11
    idx_ok   = (word[25:24] == 2'b00) && !word[21] && word[10];
    uoff_ok  = (word[25:24] == 2'b01);
    legal    = fixed_ok && (idx_ok || uoff_ok);

    if (uoff_ok)       form = FORM_UOFF;
    else if (word[11]) form = FORM_PRE;
    else               form = FORM_POST;

    is32     = word[22];
    base_idx = word[9:5];
    dst_idx  = word[4:0];

    if (uoff_ok)
      offset = {{(XLEN-U12_W-1){1'b0}}, word[21:10], 1'b0};
    else
      offset = {{(XLEN-S9_W){word[20]}}, word[20:12]};

    overlap = (word[9:5] == word[4:0]) && (word[9:5] != SP_IDX);
    wback   = !uoff_ok && !overlap;
  end
endmodule

// File: rtl/hload_agen.sv
module hload_agen
  import hload_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0] base,
  input  logic [XLEN-1:0] offset,
  input  form_e           form,
  output logic [XLEN-1:0] acc_addr,
  output logic [XLEN-1:0] upd_addr
);
  logic [XLEN-1:0] sum;

  always_comb begin
    sum      = base + offset;
    acc_addr = (form == FORM_POST) ? base : sum;
    upd_addr = sum;
  end
endmodule

// File: rtl/hload_sext.sv
module hload_sext #(
  parameter int unsigned XLEN = 64,
  parameter int unsigned HW   = 16
) (
  input  logic [HW-1:0]   data,
  input  logic            is32,
  output logic [XLEN-1:0] result
);
  localparam int unsigned NARROW = XLEN / 2;

  always_comb begin
    if (is32)
      result = {{(XLEN-NARROW){1'b0}}, {(NARROW-HW){data[HW-1]}}, data};
    else
      result = {{(XLEN-HW){data[HW-1]}}, data};
  end
endmodule

// File: rtl/hload_unit.sv
module hload_unit
  import hload_pkg::*;
#(
  parameter int unsigned XLEN          = 64,
  parameter int unsigned HW            = 16,
  parameter int unsigned SP_ALIGN_BITS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [INSN_W-1:0]    in_word,
  output logic [REG_IDX_W-1:0] rf_raddr,
  input  logic [XLEN-1:0]      rf_rdata,
  input  logic [XLEN-1:0]      sp_rdata,
  output logic                 mem_req_valid,
  input  logic                 mem_req_ready,
  output logic [XLEN-1:0]      mem_req_addr,
  input  logic                 mem_rsp_valid,
  output logic                 mem_rsp_ready,
  input  logic [HW-1:0]        mem_rsp_data,
  output logic                 res_we,
  output logic [REG_IDX_W-1:0] res_idx,
  output logic [XLEN-1:0]      res_data,
  output logic                 base_we,
  output logic [REG_IDX_W-1:0] base_idx,
  output logic [XLEN-1:0]      base_data,
  output logic                 sp_we,
  output logic [XLEN-1:0]      sp_wdata,
  output logic                 illegal,
  output logic                 align_fault
);
  logic                 d_legal, d_is32, d_wback;
  form_e                d_form;
  logic [REG_IDX_W-1:0] d_base, d_dst;
  logic [XLEN-1:0]      d_off, base_val, acc_addr, upd_addr;
  logic                 sp_misalign;

  state_e               state;
  logic [XLEN-1:0]      addr_q, upd_q;
  logic                 is32_q, wback_q, illegal_q, fault_q;
  logic [REG_IDX_W-1:0] dst_q, base_q;
  logic [HW-1:0]        data_q;

  hload_decode #(.XLEN(XLEN)) u_dec (
    .word(in_word), .legal(d_legal), .form(d_form), .is32(d_is32),
    .base_idx(d_base), .dst_idx(d_dst), .offset(d_off), .wback(d_wback)
  );

  assign rf_raddr    = d_base;
  assign base_val    = (d_base == SP_IDX) ? sp_rdata : rf_rdata;
  assign sp_misalign = (d_base == SP_IDX) && (sp_rdata[SP_ALIGN_BITS-1:0] != '0);

  hload_agen #(.XLEN(XLEN)) u_agen (
    .base(base_val), .offset(d_off), .form(d_form),
    .acc_addr(acc_addr), .upd_addr(upd_addr)
  );

  hload_sext #(.XLEN(XLEN), .HW(HW)) u_sext (
    .data(data_q), .is32(is32_q), .result(res_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      addr_q    <= '0;
      upd_q     <= '0;
      is32_q    <= 1'b0;
      wback_q   <= 1'b0;
      dst_q     <= '0;
      base_q    <= '0;
      data_q    <= '0;
      illegal_q <= 1'b0;
      fault_q   <= 1'b0;
    end else begin
      illegal_q <= 1'b0;
      fault_q   <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (in_valid) begin
            if (!d_legal) begin
              illegal_q <= 1'b1;
            end else if (sp_misalign) begin
              fault_q <= 1'b1;
            end else begin
              addr_q  <= acc_addr;
              upd_q   <= upd_addr;
              is32_q  <= d_is32;
              wback_q <= d_wback;
              dst_q   <= d_dst;
              base_q  <= d_base;
              state   <= ST_REQ;
            end
          end
        end
        ST_REQ: begin
          if (mem_req_ready) state <= ST_RSP;
        end
        ST_RSP: begin
          if (mem_rsp_valid) begin
            data_q <= mem_rsp_data;
            state  <= ST_COMMIT;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign in_ready      = (state == ST_IDLE);
  assign mem_req_valid = (state == ST_REQ);
  assign mem_req_addr  = addr_q;
  assign mem_rsp_ready = (state == ST_RSP);
  assign res_we        = (state == ST_COMMIT) && (dst_q != SP_IDX);
  assign res_idx       = dst_q;
  assign base_we       = (state == ST_COMMIT) && wback_q && (base_q != SP_IDX);
  assign base_idx      = base_q;
  assign base_data     = upd_q;
  assign sp_we         = (state == ST_COMMIT) && wback_q && (base_q == SP_IDX);
  assign sp_wdata      = upd_q;
  assign illegal       = illegal_q;
  assign align_fault   = fault_q;
endmodule

// File: rtl/hload_unit_chk.sv
module hload_unit_chk #(
  parameter int unsigned XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_ready,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [XLEN-1:0] mem_req_addr,
  input logic            mem_rsp_valid,
  input logic            mem_rsp_ready,
  input logic            res_we,
  input logic [4:0]      res_idx,
  input logic            base_we,
  input logic [4:0]      base_idx,
  input logic            sp_we,
  input logic            illegal,
  input logic            align_fault
);
  assert_illegal_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!mem_req_valid && !res_we && !base_we && !sp_we));

  assert_fault_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    align_fault |-> (!mem_req_valid && in_ready && !res_we));

  assert_no_overlap_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_we && base_we) |-> (base_idx != res_idx));

  assert_no_zero_reg_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_we |-> (res_idx != 5'd31));

  assert_sp_port_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    base_we |-> (!sp_we && base_idx != 5'd31));

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  assert_busy_no_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid || mem_rsp_ready) |-> !in_ready);

  assert_commit_after_rsp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_we || base_we || sp_we) |-> $past(mem_rsp_valid && mem_rsp_ready));
endmodule

bind hload_unit hload_unit_chk #(.XLEN(XLEN)) chk_i (.*);

// File: tb/hload_unit_tb_top.sv
module hload_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_word = '0;
  logic [4:0]  rf_raddr;
  logic [63:0] rf_rdata;
  logic [63:0] sp_rdata = '0;
  logic        mem_req_valid, mem_req_ready, mem_rsp_valid, mem_rsp_ready;
  logic [63:0] mem_req_addr;
  logic [15:0] mem_rsp_data;
  logic        res_we, base_we, sp_we, illegal, align_fault;
  logic [4:0]  res_idx, base_idx;
  logic [63:0] res_data, base_data, sp_wdata;

  logic [63:0] regs [32];
  assign rf_rdata = regs[rf_raddr];

  always #10 clk = ~clk;

  hload_unit dut_i (.*);

  typedef struct {
    int          kind;   // 0 load, 1 illegal, 2 align fault
    string       tag;
    logic [63:0] addr;
    logic        res_we;
    logic [4:0]  res_idx;
    logic [63:0] res_data;
    logic        base_we;
    logic [4:0]  base_idx;
    logic [63:0] base_data;
    logic        sp_we;
    logic [63:0] sp_data;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] memfn(input logic [63:0] a);
    return a[15:0] ^ a[31:16] ^ 16'h9C35;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // memory responder with varying request stall
  int stall = 0;
  logic [63:0] hold_addr;
  initial begin
    mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_data = '0;
    forever begin
      @(negedge clk);
      if (mem_req_valid) begin
        repeat (stall) @(negedge clk);
        mem_req_ready = 1;
        hold_addr = mem_req_addr;
        @(negedge clk);
        mem_req_ready = 0;
        mem_rsp_valid = 1;
        mem_rsp_data  = memfn(hold_addr);
        @(negedge clk);
        mem_rsp_valid = 0;
        stall = (stall + 1) % 3;
      end
    end
  end

  // monitor / scoreboard
  bit commit_next = 0;
  initial begin
    exp_t e;
    forever begin
      @(negedge clk); #8;
      if (rst_n) begin
        if (commit_next) begin
          commit_next = 0;
          if (exp_q.size() == 0) chk(0, "R10", "commit with empty queue", 1, 0);
          else begin
            e = exp_q.pop_front();
            chk(res_we == e.res_we, e.tag, "res_we", res_we, e.res_we);
            if (e.res_we) begin
              chk(res_idx == e.res_idx, e.tag, "res_idx", res_idx, e.res_idx);
              chk(res_data == e.res_data, e.tag, "res_data", res_data, e.res_data);
            end
            chk(base_we == e.base_we, e.tag, "base_we", base_we, e.base_we);
            if (e.base_we) begin
              chk(base_idx == e.base_idx, e.tag, "base_idx", base_idx, e.base_idx);
              chk(base_data == e.base_data, e.tag, "base_data", base_data, e.base_data);
            end
            chk(sp_we == e.sp_we, e.tag, "sp_we", sp_we, e.sp_we);
            if (e.sp_we) chk(sp_wdata == e.sp_data, e.tag, "sp_wdata", sp_wdata, e.sp_data);
          end
        end else if (res_we || base_we || sp_we) begin
          chk(0, "R10", "write outside commit", {res_we, base_we, sp_we}, 0);
        end
        if (illegal || align_fault) begin
          if (exp_q.size() == 0) chk(0, "R1", "flag with empty queue", {illegal, align_fault}, 0);
          else begin
            e = exp_q.pop_front();
            chk(e.kind == (illegal ? 1 : 2), e.tag, "flag kind",
                {illegal, align_fault}, (e.kind == 1) ? 2 : (e.kind == 2 ? 1 : 0));
          end
        end
        if (mem_req_valid && mem_req_ready) begin
          if (exp_q.size() == 0 || exp_q[0].kind != 0)
            chk(0, "R1", "unexpected memory request", mem_req_addr, 0);
          else
            chk(mem_req_addr == exp_q[0].addr, exp_q[0].tag, "mem_req_addr",
                mem_req_addr, exp_q[0].addr);
        end
        if (mem_rsp_valid && mem_rsp_ready) commit_next = 1;
      end
    end
  end

  task automatic drive(input logic [31:0] w, input exp_t e);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1; in_word = w;
    exp_q.push_back(e);
    @(negedge clk);
    in_valid = 0; in_word = '0;
  endtask

  task automatic expect_load(input logic [63:0] base, input logic [63:0] off,
                             input bit post, input bit wb_form, input bit is32,
                             input logic [4:0] n, input logic [4:0] t,
                             input string tag, output exp_t e);
    logic [15:0] d;
    e.tag = tag;
    if (n == 5'd31 && base[3:0] != 4'h0) begin
      e.kind = 2;
      return;
    end
    e.kind = 0;
    e.addr = post ? base : base + off;
    d = memfn(e.addr);
    e.res_we   = (t != 5'd31);
    e.res_idx  = t;
    e.res_data = is32 ? {32'h0, {16{d[15]}}, d} : {{48{d[15]}}, d};
    e.base_we  = wb_form && !(n == t) && (n != 5'd31);
    e.base_idx = n;
    e.base_data = base + off;
    e.sp_we    = wb_form && (n == 5'd31);
    e.sp_data  = base + off;
  endtask

  task automatic issue_idx(input bit pre, input bit is32, input logic [8:0] imm9,
                           input logic [4:0] n, input logic [4:0] t, input string tag);
    exp_t e;
    logic [63:0] base;
    base = (n == 5'd31) ? sp_rdata : regs[n];
    expect_load(base, {{55{imm9[8]}}, imm9}, !pre, 1, is32, n, t, tag, e);
    drive({2'b01, 3'b111, 1'b0, 2'b00, 1'b1, is32, 1'b0, imm9,
           pre ? 2'b11 : 2'b01, n, t}, e);
  endtask

  task automatic issue_uoff(input bit is32, input logic [11:0] imm12,
                            input logic [4:0] n, input logic [4:0] t, input string tag);
    exp_t e;
    logic [63:0] base;
    base = (n == 5'd31) ? sp_rdata : regs[n];
    expect_load(base, {51'h0, imm12, 1'b0}, 0, 0, is32, n, t, tag, e);
    drive({2'b01, 3'b111, 1'b0, 2'b01, 1'b1, is32, imm12, n, t}, e);
  endtask

  task automatic issue_bad(input logic [31:0] w, input string tag);
    exp_t e;
    e.kind = 1; e.tag = tag;
    drive(w, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 32; i++) regs[i] = 64'h0000_4000_0000_0000 + 64'(i) * 64'h1_2345_8761;
    repeat (3) @(negedge clk);
    // reset state, R10
    chk(in_ready == 1'b1, "R10", "reset in_ready", in_ready, 1);
    chk(mem_req_valid == 1'b0, "R10", "reset mem_req_valid", mem_req_valid, 0);
    chk({res_we, base_we, sp_we, illegal, align_fault} == 5'b0, "R10",
        "reset strobes", {res_we, base_we, sp_we, illegal, align_fault}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    issue_idx(0, 0, 9'd100, 5'd3, 5'd4, "R2 post 64-bit");
    issue_idx(0, 1, 9'h1FF, 5'd12, 5'd13, "R2 post negative 32-bit R5");
    issue_idx(1, 1, 9'h100, 5'd5, 5'd6, "R3 pre -256 R5");
    issue_idx(1, 0, 9'd255, 5'd14, 5'd15, "R3 pre +255 R5");
    issue_uoff(0, 12'hFFF, 5'd8, 5'd7, "R4 max scaled offset");
    issue_uoff(1, 12'h000, 5'd2, 5'd1, "R4 zero offset R5");
    issue_uoff(0, 12'h123, 5'd9, 5'd9, "R4 same index no writeback");
    regs[20] = 64'h0000_0000_0000_7FFE;
    issue_uoff(1, 12'h001, 5'd20, 5'd21, "R5 positive halfword");
    sp_rdata = 64'h0000_0000_8000_1230;
    issue_idx(0, 0, 9'd255, 5'd31, 5'd4, "R6 sp post");
    issue_uoff(1, 12'h010, 5'd31, 5'd4, "R6 sp scaled no writeback");
    issue_idx(1, 0, 9'h1F0, 5'd31, 5'd31, "R6 sp pre with zero dest R9");
    sp_rdata = 64'h0000_0000_8000_1238;
    issue_idx(1, 0, 9'd8, 5'd31, 5'd2, "R7 misaligned sp");
    issue_uoff(0, 12'h000, 5'd31, 5'd2, "R7 misaligned sp scaled");
    sp_rdata = 64'h0000_0000_8000_1240;
    issue_idx(1, 0, 9'd6, 5'd9, 5'd9, "R8 pre overlap suppressed");
    issue_idx(0, 1, 9'h1FE, 5'd11, 5'd11, "R8 post overlap suppressed");
    issue_idx(0, 0, 9'd2, 5'd10, 5'd31, "R9 zero dest post");
    issue_uoff(0, 12'h002, 5'd10, 5'd31, "R9 zero dest scaled");
    // illegal encodings (R1)
    issue_bad({2'b10, 3'b111, 1'b0, 2'b00, 1'b1, 1'b0, 1'b0, 9'd4, 2'b01, 5'd3, 5'd4}, "R1 size field");
    issue_bad({2'b01, 3'b111, 1'b0, 2'b00, 1'b1, 1'b0, 1'b1, 9'd4, 2'b01, 5'd3, 5'd4}, "R1 bit21 set");
    issue_bad({2'b01, 3'b111, 1'b0, 2'b00, 1'b1, 1'b0, 1'b0, 9'd4, 2'b00, 5'd3, 5'd4}, "R1 mode 00");
    issue_bad({2'b01, 3'b111, 1'b0, 2'b00, 1'b1, 1'b0, 1'b0, 9'd4, 2'b10, 5'd3, 5'd4}, "R1 mode 10");
    issue_bad({2'b01, 3'b111, 1'b0, 2'b01, 1'b0, 1'b1, 12'h004, 5'd3, 5'd4}, "R1 bit23 clear");
    issue_bad({2'b01, 3'b111, 1'b1, 2'b01, 1'b1, 1'b1, 12'h004, 5'd3, 5'd4}, "R1 bit26 set");
    issue_bad({2'b01, 3'b111, 1'b0, 2'b10, 1'b1, 1'b1, 12'h004, 5'd3, 5'd4}, "R1 class 10");
    issue_idx(1, 1, 9'd2, 5'd1, 5'd2, "R10 load after illegal");

    repeat (12) @(negedge clk);
    chk(exp_q.size() == 0, "R10", "all expectations consumed", exp_q.size(), 0);
    chk(in_ready == 1'b1, "R10", "idle at end", in_ready, 1);
    finish_run();
  end
endmodule